// File: doc/BRIEF.md
# Status Channel Frame Synchronizer

This block sits behind a 2-bit flow-control status lane that arrives already bit-aligned and de-skewed, one symbol per clock. It finds the boundaries of status frames, checks each frame's diagonal parity (DIP-2), and runs a three-state lock machine that decides when the per-port FIFO status carried by the frames may be trusted. A frame on the lane is one framing symbol `11`, an optional calendar selection symbol, `cal_len+1` status symbols (slot i describes port i), and a DIP-2 check symbol. Status symbols use the encoding 00 STARVING, 01 HUNGRY, 10 SATISFIED.

The lock machine has three states. HUNT is entered from reset, when `port_en` is low, while `nostat` is set, and on every loss of lock. HUNT goes to VALIDATE when a cleanly framed frame with a correct check symbol is seen. VALIDATE goes to IN_SYNC after `lock_thr` good frames in a row, or back to HUNT on any single bad check symbol. IN_SYNC goes back to HUNT after `loss_thr` bad check symbols in a row or after a run of twelve `11` symbols. Status is written per symbol as it arrives, forced to SATISFIED in HUNT, and forced to STARVING when `nostat` is set.

The lock state is reported as 00 HUNT, 01 VALIDATE, 10 IN_SYNC. Each mismatch seen while in IN_SYNC gives a one-cycle error pulse and bumps a saturating counter.

Top module: `stat_frame_sync`

## Requirements
- R1: After reset the lock state reads 00 (HUNT), the error counter is 0, the error pulse is low and every port reads SATISFIED (10).
- R2: The check symbol is computed with a 2-bit accumulator that starts at 00 after the framing symbol: for each selection or status symbol s, acc becomes {acc[0],acc[1]} XOR s; the expected check symbol is {acc[0],acc[1]} XOR 11. A frame whose received check symbol equals this value is good.
- R3: In HUNT a frame moves the machine to VALIDATE only if it was preceded by exactly one `11` symbol, its selection symbol equals `sel_word` when `sel_en` is set, and its check symbol is good; any other frame leaves the machine in HUNT.
- R4: In VALIDATE one bad check symbol returns the machine to HUNT without raising the error pulse or changing the error counter.
- R5: In VALIDATE, `lock_thr` consecutive good frames move the machine to IN_SYNC; a `lock_thr` of 0 acts as 1.
- R6: In IN_SYNC each bad check symbol raises `dip_err` for exactly one cycle, on the edge that samples the check symbol, and adds one to `err_cnt`, which saturates at all ones.
- R7: In IN_SYNC, `loss_thr` consecutive bad check symbols return the machine to HUNT on the edge that samples the last one; a good check symbol restarts that run; a `loss_thr` of 0 acts as 1.
- R8: In IN_SYNC, twelve consecutive `11` symbols return the machine to HUNT on the edge that samples the twelfth; a shorter run keeps the lock and the frame begins with the symbol that follows the run.
- R9: Outside HUNT, each status symbol updates its port's status on the edge that samples it, before the frame ends and regardless of the frame's check symbol; a `11` in a status slot leaves that port unchanged.
- R10: While the lock state is HUNT every port reads SATISFIED, and stored status is cleared to SATISFIED so stale values do not reappear after relock.
- R11: While `nostat` is high every port reads STARVING, the lock state is HUNT from the next edge on, and no error pulse or count occurs.
- R12: While `port_en` is low the lock state is HUNT from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one status symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low holds the lock machine in HUNT |
| nostat | input | 1 | Ignore the status lane and report STARVING everywhere |
| sym | input | 2 | Incoming status lane symbol |
| cal_len | input | CAL_W | Number of status slots per frame minus one |
| sel_en | input | 1 | Frame carries a selection symbol that must match in HUNT |
| sel_word | input | 2 | Expected selection symbol |
| lock_thr | input | 4 | Good frames needed in VALIDATE (0 acts as 1) |
| loss_thr | input | 4 | Consecutive bad frames that drop IN_SYNC (0 acts as 1) |
| port_stat | output | 2*NPORT | Per-port status, port i in bits [2i+1:2i] |
| lock_state | output | 2 | 00 HUNT, 01 VALIDATE, 10 IN_SYNC |
| dip_err | output | 1 | One-cycle pulse per mismatch while in IN_SYNC |
| err_cnt | output | ERR_W | Saturating count of those mismatches |

## Verification
The check symbol that ends the lock is the one place where error counting, the loss of lock and the clearing of status all land on the same edge. The bench enters IN_SYNC with a loss threshold of 0 and valid status already written, then sends one corrupted frame. After that one edge it expects `dip_err` high, `err_cnt` one higher, the lock state HUNT and every port SATISFIED. The vector table also crosses the lock threshold and the loss threshold on frames whose status slots are still being written.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        LK_HUNT  = 2'b00,
        LK_VALID = 2'b01,
        LK_SYNC  = 2'b10
    } lock_e;

    typedef enum logic [1:0] {
        PH_SEEK = 2'b00,
        PH_STAT = 2'b01,
        PH_DIP  = 2'b10
    } phase_e;

    localparam logic [1:0] ST_STARVE = 2'b00;
    localparam logic [1:0] ST_HUNGRY = 2'b01;
    localparam logic [1:0] ST_SAT    = 2'b10;
    localparam logic [1:0] SYM_FRAME = 2'b11;

    localparam int TRAIN_RUN = 12;
    localparam int RUN_W     = 4;
    localparam int THR_W     = 4;

    // one diagonal step: rotate the accumulator, fold in the new symbol
    function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] s);
        return {acc[0], acc[1]} ^ s;
    endfunction

    // final step treats the check slot itself as 11
    function automatic logic [1:0] dip_final(input logic [1:0] acc);
        return {acc[0], acc[1]} ^ 2'b11;
    endfunction

    function automatic logic [THR_W:0] thr_eff(input logic [THR_W-1:0] t);
        return (t == '0) ? (THR_W+1)'(1) : {1'b0, t};
    endfunction

endpackage

// File: rtl/sfs_frame_parse.sv
module sfs_frame_parse
    import sfs_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int CAL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       sym,
    input  logic [CAL_W-1:0] cal_len,
    input  logic             sel_en,
    input  logic [1:0]       sel_word,
    output logic             stat_we,
    output logic [CAL_W-1:0] stat_idx,
    output logic [1:0]       stat_val,
    output logic             dip_ev,
    output logic             dip_ok,
    output logic             hunt_ok,
    output logic             train_hit
);

    localparam logic [RUN_W-1:0] RUN_MAX  = '1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRAIN_RUN - 1);

    phase_e           ph_q, ph_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic [CAL_W-1:0] slot_q, slot_n;
    logic [1:0]       acc_q, acc_n;
    logic             multi_q, multi_n;
    logic             selbad_q, selbad_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= PH_SEEK;
            run_q    <= '0;
            slot_q   <= '0;
            acc_q    <= '0;
            multi_q  <= 1'b0;
            selbad_q <= 1'b0;
        end else begin
            ph_q     <= ph_n;
            run_q    <= run_n;
            slot_q   <= slot_n;
            acc_q    <= acc_n;
            multi_q  <= multi_n;
            selbad_q <= selbad_n;
        end
    end

    always_comb begin
        ph_n      = ph_q;
        run_n     = run_q;
        slot_n    = slot_q;
        acc_n     = acc_q;
        multi_n   = multi_q;
        selbad_n  = selbad_q;
        stat_we   = 1'b0;
        stat_idx  = slot_q;
        stat_val  = sym;
        dip_ev    = 1'b0;
        dip_ok    = 1'b0;
        hunt_ok   = 1'b0;
        train_hit = 1'b0;
        unique case (ph_q)
            PH_SEEK: begin
                if (sym == SYM_FRAME) begin
                    run_n     = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
                    train_hit = (run_q == RUN_LAST);
                end else if (run_q != '0) begin
                    run_n   = '0;
                    multi_n = (run_q != RUN_W'(1));
                    acc_n   = dip_step(2'b00, sym);
                    if (sel_en) begin
                        selbad_n = (sym != sel_word);
                        slot_n   = '0;
                        ph_n     = PH_STAT;
                    end else begin
                        selbad_n = 1'b0;
                        stat_we  = 1'b1;
                        stat_idx = '0;
                        slot_n   = CAL_W'(1);
                        ph_n     = (cal_len == '0) ? PH_DIP : PH_STAT;
                    end
                end
            end
            PH_STAT: begin
                stat_we = 1'b1;
                acc_n   = dip_step(acc_q, sym);
                if (slot_q == cal_len) ph_n = PH_DIP;
                else                   slot_n = slot_q + 1'b1;
            end
            PH_DIP: begin
                dip_ev  = 1'b1;
                dip_ok  = (sym == dip_final(acc_q));
                hunt_ok = dip_ok && !multi_q && !selbad_q;
                ph_n    = PH_SEEK;
                run_n   = '0;
            end
            default: begin
                ph_n  = PH_SEEK;
                run_n = '0;
            end
        endcase
        if (flush) begin
            ph_n      = PH_SEEK;
            run_n     = '0;
            stat_we   = 1'b0;
            dip_ev    = 1'b0;
            train_hit = 1'b0;
        end
    end

    // R2: a check symbol always hands the parser back to framing search
    a_r2_dip_then_seek: assert property (@(posedge clk) disable iff (!rst_n)
        (dip_ev && !flush) |=> (ph_q == PH_SEEK && run_q == '0));

    // R8: a training hit is only ever reported while searching for framing
    a_r8_train_in_seek: assert property (@(posedge clk) disable iff (!rst_n)
        train_hit |-> (ph_q == PH_SEEK && sym == SYM_FRAME));

endmodule

// File: rtl/sfs_lock_fsm.sv
module sfs_lock_fsm
    import sfs_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             nostat,
    input  logic [THR_W-1:0] lock_thr,
    input  logic [THR_W-1:0] loss_thr,
    input  logic             dip_ev,
    input  logic             dip_ok,
    input  logic             hunt_ok,
    input  logic             train_hit,
    output lock_e            lock_o,
    output logic             dip_err_o,
    output logic [ERR_W-1:0] err_cnt_o
);

    lock_e            state_q, state_n;
    logic [THR_W-1:0] good_q, good_n;
    logic [THR_W-1:0] bad_q, bad_n;
    logic             err_n;
    logic [ERR_W-1:0] cnt_q;
    logic             err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_HUNT;
        else        state_q <= state_n;
    end

    // next state and run counters
    always_comb begin
        state_n = state_q;
        good_n  = good_q;
        bad_n   = bad_q;
        err_n   = 1'b0;
        if (!port_en || nostat) begin
            state_n = LK_HUNT;
            good_n  = '0;
            bad_n   = '0;
        end else begin
            unique case (state_q)
                LK_HUNT: begin
                    good_n = '0;
                    bad_n  = '0;
                    if (dip_ev && hunt_ok) state_n = LK_VALID;
                end
                LK_VALID: begin
                    if (dip_ev) begin
                        if (!dip_ok) begin
                            state_n = LK_HUNT;
                        end else if (({1'b0, good_q} + 1'b1) >= thr_eff(lock_thr)) begin
                            state_n = LK_SYNC;
                            good_n  = '0;
                            bad_n   = '0;
                        end else begin
                            good_n = good_q + 1'b1;
                        end
                    end
                end
                LK_SYNC: begin
                    if (train_hit) begin
                        state_n = LK_HUNT;
                    end else if (dip_ev) begin
                        if (!dip_ok) begin
                            err_n = 1'b1;
                            if (({1'b0, bad_q} + 1'b1) >= thr_eff(loss_thr)) state_n = LK_HUNT;
                            else                                               bad_n = bad_q + 1'b1;
                        end else begin
                            bad_n = '0;
                        end
                    end
                end
                default: state_n = LK_HUNT;
            endcase
        end
    end

    // outputs: run counters, error pulse, error counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
            bad_q  <= '0;
            err_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            good_q <= good_n;
            bad_q  <= bad_n;
            err_q  <= err_n;
            if (err_n && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lock_o    = state_q;
    assign dip_err_o = err_q;
    assign err_cnt_o = cnt_q;

    // R4: one bad check symbol in VALIDATE ends it, silently
    a_r4_validate_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_VALID && port_en && !nostat && dip_ev && !dip_ok)
        |=> (state_q == LK_HUNT && !err_q && $stable(cnt_q)));

    // R6: a mismatch in IN_SYNC bumps the counter by one
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SYNC && port_en && !nostat && !train_hit && dip_ev && !dip_ok && cnt_q != '1)
        |=> (err_q && cnt_q == $past(cnt_q) + 1'b1));

    // R6: the error pulse never comes from any state but IN_SYNC
    a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LK_SYNC) |=> !err_q);

    // R8: a twelfth training symbol ends the lock
    a_r8_train_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SYNC && port_en && !nostat && train_hit) |=> (state_q == LK_HUNT));

    // R11 and R12: disabled or status-less operation parks the machine in HUNT
    a_r11_park: assert property (@(posedge clk) disable iff (!rst_n)
        (nostat || !port_en) |=> (state_q == LK_HUNT && !err_q));

endmodule

// File: rtl/sfs_port_status.sv
module sfs_port_status
    import sfs_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int CAL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_hunt,
    input  logic               nostat,
    input  logic               stat_we,
    input  logic [CAL_W-1:0]   stat_idx,
    input  logic [1:0]         stat_val,
    output logic [2*NPORT-1:0] port_stat
);

    logic [1:0] held_q [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[p] <= ST_SAT;
            end else if (in_hunt) begin
                held_q[p] <= ST_SAT;
            end else if (stat_we && stat_idx == CAL_W'(p) && stat_val != SYM_FRAME) begin
                held_q[p] <= stat_val;
            end
        end

        assign port_stat[2*p +: 2] = nostat  ? ST_STARVE :
                                     in_hunt ? ST_SAT    : held_q[p];
    end

    // R9: a status slot carrying 11 never changes the port it addresses
    a_r9_frame_sym_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hunt && stat_we && stat_val == SYM_FRAME && stat_idx == '0) |=> $stable(held_q[0]));

endmodule

// File: rtl/stat_frame_sync.sv
module stat_frame_sync
    import sfs_pkg::*;
#(
    parameter int  NPORT = 8,
    parameter int  ERR_W = 16,
    localparam int CAL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               nostat,
    input  logic [1:0]         sym,
    input  logic [CAL_W-1:0]   cal_len,
    input  logic               sel_en,
    input  logic [1:0]         sel_word,
    input  logic [3:0]         lock_thr,
    input  logic [3:0]         loss_thr,
    output logic [2*NPORT-1:0] port_stat,
    output logic [1:0]         lock_state,
    output logic               dip_err,
    output logic [ERR_W-1:0]   err_cnt
);

    localparam logic [2*NPORT-1:0] ALL_SAT = {NPORT{ST_SAT}};

    logic             flush;
    logic             stat_we;
    logic [CAL_W-1:0] stat_idx;
    logic [1:0]       stat_val;
    logic             dip_ev, dip_ok, hunt_ok, train_hit;
    lock_e            lock;

    assign flush = nostat || !port_en;

    sfs_frame_parse #(.NPORT(NPORT), .CAL_W(CAL_W)) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .sym       (sym),
        .cal_len   (cal_len),
        .sel_en    (sel_en),
        .sel_word  (sel_word),
        .stat_we   (stat_we),
        .stat_idx  (stat_idx),
        .stat_val  (stat_val),
        .dip_ev    (dip_ev),
        .dip_ok    (dip_ok),
        .hunt_ok   (hunt_ok),
        .train_hit (train_hit)
    );

    sfs_lock_fsm #(.ERR_W(ERR_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .nostat    (nostat),
        .lock_thr  (lock_thr),
        .loss_thr  (loss_thr),
        .dip_ev    (dip_ev),
        .dip_ok    (dip_ok),
        .hunt_ok   (hunt_ok),
        .train_hit (train_hit),
        .lock_o    (lock),
        .dip_err_o (dip_err),
        .err_cnt_o (err_cnt)
    );

    sfs_port_status #(.NPORT(NPORT), .CAL_W(CAL_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_hunt   (lock == LK_HUNT),
        .nostat    (nostat),
        .stat_we   (stat_we),
        .stat_idx  (stat_idx),
        .stat_val  (stat_val),
        .port_stat (port_stat)
    );

    assign lock_state = lock;

    // R10: whenever the lock reads HUNT the ports read SATISFIED
    a_r10_hunt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (lock == LK_HUNT && !nostat) |-> (port_stat == ALL_SAT));

    // R11: no status lane means every port starves
    a_r11_starve: assert property (@(posedge clk) disable iff (!rst_n)
        nostat |-> (port_stat == '0));

endmodule

// File: tb/stat_frame_sync_test.sv
`timescale 1ns/1ps
module stat_frame_sync_test;

    localparam int NPORT = 8;
    localparam int ERR_W = 16;
    localparam int CAL_W = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               port_en = 1'b1;
    logic               nostat = 1'b0;
    logic [1:0]         sym = 2'b00;
    logic [CAL_W-1:0]   cal_len = 3'd3;
    logic               sel_en = 1'b0;
    logic [1:0]         sel_word = 2'b00;
    logic [3:0]         lock_thr = 4'd2;
    logic [3:0]         loss_thr = 4'd2;
    logic [2*NPORT-1:0] port_stat;
    logic [1:0]         lock_state;
    logic               dip_err;
    logic [ERR_W-1:0]   err_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    stat_frame_sync #(.NPORT(NPORT), .ERR_W(ERR_W)) uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .nostat(nostat),
        .sym(sym), .cal_len(cal_len), .sel_en(sel_en), .sel_word(sel_word),
        .lock_thr(lock_thr), .loss_thr(loss_thr), .port_stat(port_stat),
        .lock_state(lock_state), .dip_err(dip_err), .err_cnt(err_cnt)
    );

    localparam logic [1:0] HUNT = 2'b00, VALID = 2'b01, SYNC = 2'b10;

    // {corrupt, status s3..s0, lock after, err_cnt after}; lock_thr=2, loss_thr=2
    localparam logic [14:0] VEC [8] = '{
        {1'b0, 8'b00_01_10_01, VALID, 4'd0},
        {1'b0, 8'b01_00_01_10, VALID, 4'd0},
        {1'b0, 8'b10_10_00_01, SYNC,  4'd0},
        {1'b1, 8'b00_00_01_01, SYNC,  4'd1},
        {1'b0, 8'b01_10_00_00, SYNC,  4'd1},
        {1'b1, 8'b10_01_01_00, SYNC,  4'd2},
        {1'b1, 8'b00_01_10_01, HUNT,  4'd3},
        {1'b0, 8'b01_01_01_01, VALID, 4'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] s);
        sym = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] dip_of(input logic [15:0] st, input logic [1:0] selv);
        logic [1:0] acc = 2'b00;
        if (sel_en) acc = {acc[0], acc[1]} ^ selv;
        for (int i = 0; i <= int'(cal_len); i++) acc = {acc[0], acc[1]} ^ st[2*i +: 2];
        return {acc[0], acc[1]} ^ 2'b11;
    endfunction

    task automatic send_frame(input logic [15:0] st, input logic bad, input logic [1:0] selv);
        send(2'b11);
        if (sel_en) send(selv);
        for (int i = 0; i <= int'(cal_len); i++) send(st[2*i +: 2]);
        send(dip_of(st, selv) ^ (bad ? 2'b01 : 2'b00));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0]  prev_lock;
        logic [15:0] exp_stat;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 lock", 32'(lock_state), 32'(HUNT));
        chk("R1 err_cnt", 32'(err_cnt), 0);
        chk("R1 dip_err", 32'(dip_err), 0);
        chk("R1 status", 32'(port_stat), 32'h0000_AAAA);

        // table walk: R2 R3 R5 R6 R7 R9 R10
        prev_lock = HUNT;
        for (int v = 0; v < 8; v++) begin
            send_frame({8'h00, VEC[v][13:6]}, VEC[v][14], 2'b00);
            chk($sformatf("R2/R5/R7 vec%0d lock", v), 32'(lock_state), 32'(VEC[v][5:4]));
            chk($sformatf("R6 vec%0d err_cnt", v), 32'(err_cnt), 32'(VEC[v][3:0]));
            chk($sformatf("R6 vec%0d dip_err", v), 32'(dip_err),
                32'(VEC[v][14] && prev_lock == SYNC));
            exp_stat = (prev_lock == HUNT || VEC[v][5:4] == HUNT) ? 16'hAAAA
                                                                  : {8'hAA, VEC[v][13:6]};
            chk($sformatf("R9/R10 vec%0d status", v), 32'(port_stat), 32'(exp_stat));
            prev_lock = VEC[v][5:4];
        end

        // reach IN_SYNC, then R9: status appears per symbol, mid-frame
        send_frame(16'h00A6, 1'b0, 2'b00);
        send_frame({8'h00, 8'b10_01_00_01}, 1'b0, 2'b00);
        chk("R5 second good frame locks", 32'(lock_state), 32'(SYNC));
        send(2'b11);
        send(2'b01);
        chk("R9 port0 updated mid-frame", 32'(port_stat[1:0]), 32'(2'b01));
        chk("R9 port1 not yet updated", 32'(port_stat[3:2]), 32'(2'b00));
        send(2'b10);
        send(2'b10);
        send(2'b00);
        begin
            logic [1:0] a = 2'b00;
            a = {a[0], a[1]} ^ 2'b01;
            a = {a[0], a[1]} ^ 2'b10;
            a = {a[0], a[1]} ^ 2'b10;
            a = {a[0], a[1]} ^ 2'b00;
            send({a[0], a[1]} ^ 2'b11);
        end
        chk("R9 frame good keeps lock", 32'(lock_state), 32'(SYNC));
        // R9: slot 2 carries 11, port2 keeps 10
        send_frame({8'h00, 8'b00_11_01_10}, 1'b0, 2'b00);
        chk("R9 11 in slot leaves port", 32'(port_stat[7:0]), 32'(8'b00_10_01_10));
        chk("R2 frame with 11 slot still good", 32'(err_cnt), 32'd3);

        // R8: eleven-symbol run keeps lock, frame after it decodes
        for (int i = 0; i < 10; i++) send(2'b11);
        send_frame({8'h00, 8'b01_00_10_00}, 1'b0, 2'b00);
        chk("R8 short training keeps lock", 32'(lock_state), 32'(SYNC));
        chk("R8 frame after training decoded", 32'(port_stat[7:0]), 32'(8'b01_00_10_00));
        for (int i = 0; i < 11; i++) send(2'b11);
        chk("R8 eleven still locked", 32'(lock_state), 32'(SYNC));
        send(2'b11);
        chk("R8 twelfth drops lock", 32'(lock_state), 32'(HUNT));
        chk("R10 status cleared on drop", 32'(port_stat), 32'h0000_AAAA);
        send(2'b00);

        // R3: doubled framing symbol is rejected in HUNT
        send(2'b11);
        send_frame(16'h0015, 1'b0, 2'b00);
        chk("R3 double framing stays HUNT", 32'(lock_state), 32'(HUNT));
        send_frame(16'h0015, 1'b0, 2'b00);
        chk("R3 single framing validates", 32'(lock_state), 32'(VALID));

        // R4: one bad frame in VALIDATE, no error accounting
        send_frame(16'h0015, 1'b1, 2'b00);
        chk("R4 drop to HUNT", 32'(lock_state), 32'(HUNT));
        chk("R4 no pulse", 32'(dip_err), 0);
        chk("R4 count kept", 32'(err_cnt), 32'd3);

        // R3: selection symbol must match
        sel_en = 1'b1;
        sel_word = 2'b01;
        send_frame(16'h0021, 1'b0, 2'b10);
        chk("R3 wrong selection stays HUNT", 32'(lock_state), 32'(HUNT));
        send_frame(16'h0021, 1'b0, 2'b01);
        chk("R3 matching selection validates", 32'(lock_state), 32'(VALID));

        // R5: zero lock threshold acts as one
        lock_thr = 4'd0;
        send_frame(16'h0021, 1'b0, 2'b01);
        chk("R5 zero threshold locks at once", 32'(lock_state), 32'(SYNC));
        chk("R9 status after lock", 32'(port_stat[7:0]), 32'(8'h21));

        // R7 + R6 + R10 on one edge: zero loss threshold
        loss_thr = 4'd0;
        send_frame(16'h0021, 1'b1, 2'b01);
        chk("R7 zero threshold drops at once", 32'(lock_state), 32'(HUNT));
        chk("R6 pulse on dropping edge", 32'(dip_err), 1);
        chk("R6 count on dropping edge", 32'(err_cnt), 32'd4);
        chk("R10 status cleared same edge", 32'(port_stat), 32'h0000_AAAA);
        send(2'b00);
        chk("R6 pulse lasts one cycle", 32'(dip_err), 0);

        // R11: no status mode
        send_frame(16'h0021, 1'b0, 2'b01);
        chk("R11 precondition validate", 32'(lock_state), 32'(VALID));
        nostat = 1'b1;
        send(2'b00);
        chk("R11 parked in HUNT", 32'(lock_state), 32'(HUNT));
        chk("R11 all starving", 32'(port_stat), 32'h0000_0000);
        send_frame(16'h0021, 1'b0, 2'b01);
        send_frame(16'h0021, 1'b1, 2'b01);
        chk("R11 frames ignored", 32'(lock_state), 32'(HUNT));
        chk("R11 no errors counted", 32'(err_cnt), 32'd4);
        nostat = 1'b0;
        send(2'b00);
        chk("R10 leaving nostat shows SATISFIED", 32'(port_stat), 32'h0000_AAAA);

        // R12: port disable
        send_frame(16'h0021, 1'b0, 2'b01);
        chk("R12 precondition validate", 32'(lock_state), 32'(VALID));
        port_en = 1'b0;
        send(2'b00);
        chk("R12 disable forces HUNT", 32'(lock_state), 32'(HUNT));
        port_en = 1'b1;
        send(2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule